// File: doc/BRIEF.md
# Cycle-Steal Multi-Channel DMA Controller

This block moves data on behalf of peripherals over a data bus that it shares with a CPU. It has four channels. Each channel joins a fixed peripheral-register address to a memory address. Each request pulse on a channel moves exactly one unit, either a byte or a 16-bit word. To do so the controller asks the CPU for the bus, waits for the acknowledge, and runs one read cycle and one write cycle. It then gives the bus back straight away. The controller always outranks the CPU: once it raises its hold request, the CPU must yield.

Software programs each channel through a narrow write port. The values it sets are a mode word, the memory address, the peripheral address, a transfer count, and reload copies of the count and of the memory address. After each unit the memory address steps by the unit size, or stays put, and the count falls by one. When the count runs out the channel signals terminal count. In single mode it then switches itself off. In repeat mode it restores the count and the memory address from the reload copies and stays armed.

Top module: `dma_cs_ctrl`

## Requirements
- R1: After a synchronous reset, `hold_req`, `bus_rd`, `bus_wr` and every `done` bit are low, and every channel is disabled with all of its registers at zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register of channel `cfg_ch` chosen by `cfg_sel`. The select codes are: 0 mode, 1 memory address, 2 peripheral address, 3 count, 4 count reload, 5 memory-address reload. The mode bits are: bit0 enable, bit1 word size, bit2 direction, bit3 repeat, bit4 address step.
- R3: A one-cycle pulse on `dreq[i]` is accepted only while channel i is enabled and its count is nonzero. A pulse that arrives while the channel is disabled is dropped and produces no bus activity.
- R4: The controller raises `hold_req` before any transfer. It drives `bus_rd` or `bus_wr` only while both `hold_req` and `hold_ack` are high.
- R5: Each accepted request causes exactly one read cycle, then a write cycle in the next clock. In the clock after the write, `hold_req` is dropped.
- R6: Direction bit 0 reads the peripheral address and writes the memory address. Direction bit 1 does the opposite.
- R7: In word mode `bus_word` is high and all 16 read bits are written. In byte mode `bus_word` is low, the low 8 read bits are written, and the upper 8 write bits are zero.
- R8: After each unit the memory address grows by 1 (byte) or by 2 (word) when the step bit is set, and stays the same when it is clear. The peripheral address never changes.
- R9: In single mode (repeat bit 0), the unit that brings the count to zero pulses `done[i]` for one cycle and clears the channel's enable. Further requests are then dropped. The reload registers have no effect.
- R10: In repeat mode, the unit that brings the count to zero pulses `done[i]`. It also reloads the count and the memory address from their reload registers, and the channel stays enabled.
- R11: When more than one channel is pending while the bus is idle, channel 0 is served first and channel 3 last. Arbitration happens only while no transfer is in progress.
- R12: A request that arrives for a channel while that channel's own transfer is under way is latched. It is served as a further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel to which the write is directed |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 16 | Register write value |
| dreq | input | 4 | Transfer request pulses, one per channel |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | CPU has released the bus |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | High for a 16-bit cycle, low for a byte cycle |
| bus_rdata | input | 16 | Read data, valid during the read cycle |
| bus_wdata | output | 16 | Write data, valid during the write cycle |
| done | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
Broken address state in a channel shows up at the very next transfer of that channel. Its read or write address on the bus moves off the expected sequence, and the scoreboard sees this during that write cycle. A wrong count or a wrong mode bit shows up later, at the unit where the terminal count should occur. The `done` pulse comes early, late or not at all, or a channel that should be disabled still moves data. The bench catches this through its pulse tallies and its transfer counter, within about ten clocks of the request in question. A sequencer that strays from its read-write-release order is caught on the cycle it happens.

// File: rtl/dmacs_pkg.sv
package dmacs_pkg;

    localparam int DW = 16;

    localparam logic [2:0] SEL_MODE   = 3'd0;
    localparam logic [2:0] SEL_MEM    = 3'd1;
    localparam logic [2:0] SEL_PER    = 3'd2;
    localparam logic [2:0] SEL_CNT    = 3'd3;
    localparam logic [2:0] SEL_CNT_RL = 3'd4;
    localparam logic [2:0] SEL_MEM_RL = 3'd5;

    typedef struct packed {
        logic step;
        logic rpt;
        logic to_periph;
        logic word;
        logic en;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_READ,
        ST_WRITE
    } bus_st_e;

    function automatic logic [1:0] step_of(mode_t m);
        if (!m.step)
            return 2'd0;
        return m.word ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [DW-1:0] fit_data(logic word, logic [DW-1:0] d);
        return word ? d : {{(DW-8){1'b0}}, d[7:0]};
    endfunction

endpackage

// File: rtl/dmacs_chan.sv
module dmacs_chan
    import dmacs_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          req,
    input  logic          grant,
    input  logic          fin,
    output mode_t         mode,
    output logic          pend,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] per_addr,
    output logic          tc
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_rl;
    logic [AW-1:0] mem_rl;
    logic          last;
    logic [AW-1:0] mem_next;

    assign last     = (cnt == CW'(1));
    assign mem_next = mem_addr + AW'(step_of(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            pend     <= 1'b0;
            mem_addr <= '0;
            per_addr <= '0;
            cnt      <= '0;
            cnt_rl   <= '0;
            mem_rl   <= '0;
            tc       <= 1'b0;
        end else begin
            tc <= 1'b0;

            if (grant)
                pend <= 1'b0;
            if (req && mode.en && (cnt != '0))
                pend <= 1'b1;

            if (fin) begin
                if (last) begin
                    tc <= 1'b1;
                    if (mode.rpt) begin
                        cnt      <= cnt_rl;
                        mem_addr <= mem_rl;
                    end else begin
                        cnt      <= '0;
                        mode.en  <= 1'b0;
                        pend     <= 1'b0;
                        mem_addr <= mem_next;
                    end
                end else begin
                    cnt      <= cnt - CW'(1);
                    mem_addr <= mem_next;
                end
            end

            if (wr_en) begin
                case (wr_sel)
                    SEL_MODE: begin
                        mode <= mode_t'(wr_data[4:0]);
                        if (!wr_data[0])
                            pend <= 1'b0;
                    end
                    SEL_MEM:    mem_addr <= wr_data;
                    SEL_PER:    per_addr <= wr_data;
                    SEL_CNT:    cnt      <= wr_data[CW-1:0];
                    SEL_CNT_RL: cnt_rl   <= wr_data[CW-1:0];
                    SEL_MEM_RL: mem_rl   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmacs_arb.sv
module dmacs_arb #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] pend,
    output logic [NCH-1:0] pick,
    output logic [IW-1:0]  idx,
    output logic           any
);

    always_comb begin
        pick = '0;
        idx  = '0;
        any  = |pend;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
                idx     = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dmacs_seq.sv
module dmacs_seq
    import dmacs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     any,
    input  logic [IW-1:0]            idx,
    input  mode_t [NCH-1:0]          modes,
    input  logic [NCH-1:0][AW-1:0]   mems,
    input  logic [NCH-1:0][AW-1:0]   pers,
    input  logic                     hold_ack,
    input  logic [DW-1:0]            bus_rdata,
    output logic                     idle,
    output logic [NCH-1:0]           fin,
    output logic                     hold_req,
    output logic [AW-1:0]            bus_addr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic                     bus_word,
    output logic [DW-1:0]            bus_wdata
);

    bus_st_e       st;
    logic [IW-1:0] act;
    logic [DW-1:0] dbuf;
    mode_t         m;
    logic [AW-1:0] src;
    logic [AW-1:0] dst;

    assign m   = modes[act];
    assign src = m.to_periph ? mems[act] : pers[act];
    assign dst = m.to_periph ? pers[act] : mems[act];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            act  <= '0;
            dbuf <= '0;
        end else begin
            case (st)
                ST_IDLE: if (any) begin
                    act <= idx;
                    st  <= ST_HOLD;
                end
                ST_HOLD: if (hold_ack)
                    st <= ST_READ;
                ST_READ: begin
                    dbuf <= fit_data(m.word, bus_rdata);
                    st   <= ST_WRITE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (st == ST_IDLE);
        hold_req  = !idle;
        bus_rd    = (st == ST_READ);
        bus_wr    = (st == ST_WRITE);
        bus_word  = (bus_rd || bus_wr) && m.word;
        bus_addr  = bus_rd ? src : (bus_wr ? dst : '0);
        bus_wdata = bus_wr ? dbuf : '0;
        fin       = '0;
        if (bus_wr)
            fin[act] = 1'b1;
    end

endmodule

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl
    import dmacs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [$clog2(NCH)-1:0]  cfg_ch,
    input  logic [2:0]              cfg_sel,
    input  logic [AW-1:0]           cfg_wdata,
    input  logic [NCH-1:0]          dreq,
    output logic                    hold_req,
    input  logic                    hold_ack,
    output logic [AW-1:0]           bus_addr,
    output logic                    bus_rd,
    output logic                    bus_wr,
    output logic                    bus_word,
    input  logic [DW-1:0]           bus_rdata,
    output logic [DW-1:0]           bus_wdata,
    output logic [NCH-1:0]          done
);

    localparam int IW = $clog2(NCH);

    mode_t [NCH-1:0]        modes;
    logic  [NCH-1:0][AW-1:0] mems;
    logic  [NCH-1:0][AW-1:0] pers;
    logic  [NCH-1:0]        pend;
    logic  [NCH-1:0]        pick;
    logic  [NCH-1:0]        fin;
    logic  [IW-1:0]         idx;
    logic                   any;
    logic                   idle;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmacs_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_we && (cfg_ch == IW'(g))),
            .wr_sel   (cfg_sel),
            .wr_data  (cfg_wdata),
            .req      (dreq[g]),
            .grant    (pick[g] && idle),
            .fin      (fin[g]),
            .mode     (modes[g]),
            .pend     (pend[g]),
            .mem_addr (mems[g]),
            .per_addr (pers[g]),
            .tc       (done[g])
        );
    end

    dmacs_arb #(.NCH(NCH)) u_arb (
        .pend (pend),
        .pick (pick),
        .idx  (idx),
        .any  (any)
    );

    dmacs_seq #(.NCH(NCH), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .any       (any),
        .idx       (idx),
        .modes     (modes),
        .mems      (mems),
        .pers      (pers),
        .hold_ack  (hold_ack),
        .bus_rdata (bus_rdata),
        .idle      (idle),
        .fin       (fin),
        .hold_req  (hold_req),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/dmacs_chk.sv
module dmacs_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic [NCH-1:0] done
);

    a_r4_bus_needs_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> (hold_req && hold_ack));

    a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_wr);

    a_r5_write_has_read: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $past(bus_rd));

    a_r5_release_after_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !hold_req);

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    a_r9_done_is_pulse: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> !(|(done & $past(done))));

endmodule

bind dma_cs_ctrl dmacs_chk #(.NCH(NCH)) u_dmacs_chk (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .done     (done)
);

// File: tb/test_dma_cs_ctrl.sv
module test_dma_cs_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] KEY = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  dreq = '0;
    logic        hold_req;
    logic        hold_ack;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_word;
    logic [15:0] bus_rdata;
    logic [15:0] bus_wdata;
    logic [3:0]  done;

    typedef struct {
        logic [15:0] ra;
        logic [15:0] wa;
        logic [15:0] d;
        logic        w;
        string       tag;
    } xp_t;

    xp_t q[$];
    int  checks = 0;
    int  errors = 0;
    int  writes = 0;
    int  done_cnt [4];
    int  cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cs_ctrl i_dma_cs_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .hold_req(hold_req), .hold_ack(hold_ack),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .done(done)
    );

    // CPU model: yields one clock after being asked; memory returns address ^ KEY
    always_ff @(posedge clk) hold_ack <= rst ? 1'b0 : hold_req;
    assign bus_rdata = bus_addr ^ KEY;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_x(input logic [15:0] ra, input logic [15:0] wa, input logic w, input string tag);
        xp_t e;
        logic [15:0] raw;
        raw   = ra ^ KEY;
        e.ra  = ra;
        e.wa  = wa;
        e.w   = w;
        e.d   = w ? raw : {8'h00, raw[7:0]};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            for (int i = 0; i < 4; i++)
                if (done[i]) done_cnt[i]++;
            if (bus_rd || bus_wr) begin
                chk(hold_ack && hold_req, "R4 bus used with hold granted", {30'd0, hold_req, hold_ack}, 32'd3);
                if (q.size() == 0) begin
                    chk(1'b0, "R3 unexpected bus cycle", {16'd0, bus_addr}, 32'd0);
                end else if (bus_rd) begin
                    chk(bus_addr == q[0].ra, {q[0].tag, " read address"}, bus_addr, q[0].ra);
                    chk(bus_word == q[0].w, "R7 size on read", bus_word, q[0].w);
                end else begin
                    chk(bus_addr == q[0].wa, {q[0].tag, " write address"}, bus_addr, q[0].wa);
                    chk(bus_wdata == q[0].d, "R7 write data", bus_wdata, q[0].d);
                    writes++;
                    void'(q.pop_front());
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cfg(input logic [1:0] ch, input logic [2:0] sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        dreq = m;
        @(negedge clk);
        dreq = '0;
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        chk(!hold_req && !bus_rd && !bus_wr && done == 0, "R1 outputs in reset",
            {28'd0, hold_req, bus_rd, bus_wr, |done}, 32'd0);
        rst = 1'b0;
        // R1: channels disabled after reset, so requests do nothing
        w0 = writes;
        pulse(4'hF);
        settle();
        chk(writes == w0 && !hold_req, "R1 channels disabled after reset", writes - w0, 0);

        // ch0: byte, periph->mem, step, single, count 3 (R2 R6 R8 R9)
        cfg(0, 3'd2, 16'h0100);
        cfg(0, 3'd1, 16'h2000);
        cfg(0, 3'd3, 16'd3);
        cfg(0, 3'd0, 16'h0011);
        for (int k = 0; k < 3; k++) begin
            expect_x(16'h0100, 16'h2000 + 16'(k), 1'b0, "R6 R8 ch0 byte");
            pulse(4'b0001);
            settle();
        end
        chk(done_cnt[0] == 1, "R9 done after count end", done_cnt[0], 1);
        w0 = writes;
        pulse(4'b0001);
        settle();
        chk(writes == w0, "R9 R3 disabled channel drops request", writes - w0, 0);

        // ch1: word, mem->periph, step, repeat (R10 R7 R6)
        cfg(1, 3'd2, 16'h0200);
        cfg(1, 3'd1, 16'h3000);
        cfg(1, 3'd3, 16'd2);
        cfg(1, 3'd4, 16'd2);
        cfg(1, 3'd5, 16'h3100);
        cfg(1, 3'd0, 16'h001F);
        expect_x(16'h3000, 16'h0200, 1'b1, "R6 R7 ch1 word");
        pulse(4'b0010); settle();
        expect_x(16'h3002, 16'h0200, 1'b1, "R8 ch1 step two");
        pulse(4'b0010); settle();
        chk(done_cnt[1] == 1, "R10 done in repeat", done_cnt[1], 1);
        expect_x(16'h3100, 16'h0200, 1'b1, "R10 ch1 reloaded address");
        pulse(4'b0010); settle();

        // ch2: byte, no step (R8)
        cfg(2, 3'd2, 16'h0300);
        cfg(2, 3'd1, 16'h4000);
        cfg(2, 3'd3, 16'd4);
        cfg(2, 3'd0, 16'h0001);
        for (int k = 0; k < 2; k++) begin
            expect_x(16'h0300, 16'h4000, 1'b0, "R8 ch2 fixed address");
            pulse(4'b0100);
            settle();
        end

        // priority (R11)
        cfg(0, 3'd1, 16'h2100);
        cfg(0, 3'd3, 16'd5);
        cfg(0, 3'd0, 16'h0011);
        cfg(3, 3'd2, 16'h0400);
        cfg(3, 3'd1, 16'h5000);
        cfg(3, 3'd3, 16'd5);
        cfg(3, 3'd0, 16'h0003);
        expect_x(16'h0100, 16'h2100, 1'b0, "R11 ch0 first");
        expect_x(16'h0300, 16'h4000, 1'b0, "R11 ch2 second");
        expect_x(16'h0400, 16'h5000, 1'b1, "R11 ch3 last");
        pulse(4'b1101);
        repeat (30) @(negedge clk);
        chk(q.size() == 0, "R11 all three served", q.size(), 0);

        // request during own transfer is latched (R12), repeat reload on the way
        expect_x(16'h3102, 16'h0200, 1'b1, "R12 ch1 first");
        expect_x(16'h3100, 16'h0200, 1'b1, "R12 ch1 latched");
        pulse(4'b0010);
        repeat (2) @(negedge clk);
        chk(hold_req, "R5 transfer in progress", hold_req, 1);
        pulse(4'b0010);
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R12 latched request served", q.size(), 0);
        chk(done_cnt[1] == 2, "R10 second terminal count", done_cnt[1], 2);
        chk(!hold_req, "R5 bus released when idle", hold_req, 0);

        // single mode ignores reload registers (R9)
        cfg(0, 3'd4, 16'd9);
        cfg(0, 3'd5, 16'h7000);
        cfg(0, 3'd3, 16'd1);
        expect_x(16'h0100, 16'h2101, 1'b0, "R9 ch0 last unit");
        pulse(4'b0001); settle();
        chk(done_cnt[0] == 2, "R9 done pulse", done_cnt[0], 2);
        cfg(0, 3'd3, 16'd1);
        cfg(0, 3'd0, 16'h0011);
        expect_x(16'h0100, 16'h2102, 1'b0, "R9 reload ignored");
        pulse(4'b0001); settle();

        chk(q.size() == 0, "R5 every request served once", q.size(), 0);
        chk(done_cnt[2] == 0 && done_cnt[3] == 0, "R9 no early done", done_cnt[2] + done_cnt[3], 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule